// File: doc/BRIEF.md
# PLL Power Sequencer

This block drives the control pins of an analog PLL core through its start-up and shut-down steps, so software does not have to time them. Software sees one 32-bit mode register. It requests a start or a stop with single-cycle command pulses. The block reports each finished request with a `done` pulse, or with a `timeout` pulse when the PLL never confirms. All waits are counted in microsecond ticks. The ticks come from a prescaler whose period in system clocks is set at a port.

There are two ways of running the PLL.

- **Direct mode:** the sequencer itself works the active-low bypass and reset lines and the output gate. It observes a minimum settling delay between releasing bypass and releasing reset. It bounds its wait for lock. When stopping, it gates the output before it drops reset and bypass.
- **Vote mode:** an external arbiter owns the PLL. The sequencer only raises or withdraws a vote request, and it waits for the arbiter's active flag instead of lock.

Top module: `pllseq`

## Requirements
- R1: A synchronous active-high `rst` clears the output gate, bypass-not, reset-not, the vote request, the lock-count, bias-count and vote-mode fields, `busy`, `done` and `timeout`. It also returns the sequencer to idle, from any state.
- R2: Mode register layout:
  - bit 0 is the output gate, bit 1 is bypass-not and bit 2 is reset-not;
  - bits 13:8 hold the lock count, bits 19:14 the bias count, and bit 20 is vote mode;
  - bit 30 reads `active_flag` and bit 31 reads `lock_det`, live;
  - all other bits read 0.
  A write taken while idle updates bits 0 to 2 and 8 to 20, and the new value is readable on the next cycle.
- R3: A start request in direct mode, when the output gate, bypass-not and reset-not are all already 1, changes nothing and gives `done` on the next cycle.
- R4: A direct start sets bypass-not on the cycle after the request. It sets reset-not exactly BYPASS_US microsecond ticks later, one tick being `tick_div`+1 clocks. It sets the output gate, with `done`, on the cycle after `lock_det` is seen high.
- R5: If `lock_det` is still low after POLL_MAX ticks of the lock wait, the block pulses `timeout`, returns to idle and leaves the output gate at 0.
- R6: A direct stop clears the output gate on the cycle after the request. It clears reset-not and bypass-not together, with `done`, exactly OFF_US ticks later.
- R7: In vote mode, a start request only raises `vote_req`. The block gives `done` on the cycle after `active_flag` is seen high, or `timeout` after POLL_MAX ticks without it. `vote_req` stays high in both cases.
- R8: In vote mode, a stop request only lowers `vote_req` and gives `done` on the next cycle. The three control pins keep their values.
- R9: `busy` is high while a sequence runs. Start and stop requests and register writes taken while `busy` is high have no effect.
- R10: `done` and `timeout` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_div | input | DIV_W | System clocks per microsecond, minus one |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 32 | Mode register write data |
| mode_rdata | output | 32 | Mode register read value |
| cmd_enable | input | 1 | Start request pulse |
| cmd_disable | input | 1 | Stop request pulse |
| lock_det | input | 1 | Lock indication from the PLL core |
| active_flag | input | 1 | Active indication from the vote arbiter |
| pll_out_en | output | 1 | Output gate to the PLL core |
| pll_bypass_n | output | 1 | Active-low bypass to the PLL core |
| pll_reset_n | output | 1 | Active-low reset to the PLL core |
| vote_req | output | 1 | Vote request to the arbiter |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Request completed pulse |
| timeout | output | 1 | Lock or active wait expired pulse |

## Verification
If the delay counter or the prescaler held a wrong value, the release of reset-not, or the drop of reset-not and bypass-not, would move by whole microsecond ticks. The bench therefore samples these pins one clock before and one clock after their exact expected edge. A sequencer stuck in the wrong state shows up as `busy` held high, or as a missing `done` or `timeout` on the cycle where the bench expects it. A state that wrongly accepted a request while busy shows up at once, as an early change on the output gate or the mode register readback. The lock and active waits are checked on the cycle where `timeout` must appear, 100 ticks after the wait starts.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_BYP_WAIT,
    S_LOCK_POLL,
    S_OFF_WAIT,
    S_VOTE_POLL
  } seq_state_e;

  localparam int REG_W    = 32;
  localparam int FIELD_W  = 6;
  localparam int OE_BIT   = 0;
  localparam int BYPN_BIT = 1;
  localparam int RSTN_BIT = 2;
  localparam int LCNT_LSB = 8;
  localparam int BCNT_LSB = 14;
  localparam int VOTE_BIT = 20;
  localparam int ACT_BIT  = 30;
  localparam int LOCK_BIT = 31;
endpackage

// File: rtl/pllseq_tick.sv
module pllseq_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt >= div) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
  import pllseq_pkg::*;
#(
  parameter int BYPASS_US = 5,
  parameter int OFF_US    = 1,
  parameter int POLL_MAX  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  output logic       tick_clr,
  input  logic       cmd_en,
  input  logic       cmd_dis,
  input  logic       vote_mode,
  input  logic       lock_det,
  input  logic       active_flag,
  input  logic       ctl_we,
  input  logic [2:0] ctl_wdata,
  output logic       oe,
  output logic       byp_n,
  output logic       rst_n,
  output logic       vote_req,
  output logic       busy,
  output logic       done,
  output logic       timeout
);
  localparam int MAX_A = (BYPASS_US > OFF_US) ? BYPASS_US : OFF_US;
  localparam int MAX_V = (MAX_A > POLL_MAX) ? MAX_A : POLL_MAX;
  localparam int CNT_W = $clog2(MAX_V + 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             last_tick;

  assign last_tick = tick && (cnt == CNT_W'(1));
  assign busy      = (state != S_IDLE);
  assign tick_clr  = ((state == S_IDLE) && (cmd_en || cmd_dis)) ||
                     ((state == S_BYP_WAIT) && last_tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      oe       <= 1'b0;
      byp_n    <= 1'b0;
      rst_n    <= 1'b0;
      vote_req <= 1'b0;
      done     <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmd_en) begin
            if (vote_mode) begin
              vote_req <= 1'b1;
              cnt      <= CNT_W'(POLL_MAX);
              state    <= S_VOTE_POLL;
            end else if (oe && byp_n && rst_n) begin
              done <= 1'b1;
            end else begin
              byp_n <= 1'b1;
              cnt   <= CNT_W'(BYPASS_US);
              state <= S_BYP_WAIT;
            end
          end else if (cmd_dis) begin
            if (vote_mode) begin
              vote_req <= 1'b0;
              done     <= 1'b1;
            end else begin
              oe    <= 1'b0;
              cnt   <= CNT_W'(OFF_US);
              state <= S_OFF_WAIT;
            end
          end else if (ctl_we) begin
            oe    <= ctl_wdata[OE_BIT];
            byp_n <= ctl_wdata[BYPN_BIT];
            rst_n <= ctl_wdata[RSTN_BIT];
          end
        end
        S_BYP_WAIT: begin
          if (last_tick) begin
            rst_n <= 1'b1;
            cnt   <= CNT_W'(POLL_MAX);
            state <= S_LOCK_POLL;
          end else if (tick) begin
            cnt <= cnt - 1'b1;
          end
        end
        S_LOCK_POLL: begin
          if (lock_det) begin
            oe    <= 1'b1;
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (last_tick) begin
            timeout <= 1'b1;
            state   <= S_IDLE;
          end else if (tick) begin
            cnt <= cnt - 1'b1;
          end
        end
        S_OFF_WAIT: begin
          if (last_tick) begin
            rst_n <= 1'b0;
            byp_n <= 1'b0;
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (tick) begin
            cnt <= cnt - 1'b1;
          end
        end
        S_VOTE_POLL: begin
          if (active_flag) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (last_tick) begin
            timeout <= 1'b1;
            state   <= S_IDLE;
          end else if (tick) begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pllseq.sv
module pllseq
  import pllseq_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int BYPASS_US = 5,
  parameter int OFF_US    = 1,
  parameter int POLL_MAX  = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] tick_div,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      mode_rdata,
  input  logic             cmd_enable,
  input  logic             cmd_disable,
  input  logic             lock_det,
  input  logic             active_flag,
  output logic             pll_out_en,
  output logic             pll_bypass_n,
  output logic             pll_reset_n,
  output logic             vote_req,
  output logic             busy,
  output logic             done,
  output logic             timeout
);
  logic               tick;
  logic               tick_clr;
  logic [FIELD_W-1:0] lock_cnt_q;
  logic [FIELD_W-1:0] bias_cnt_q;
  logic               vote_en_q;

  pllseq_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (tick_clr),
    .div  (tick_div),
    .tick (tick)
  );

  pllseq_fsm #(
    .BYPASS_US (BYPASS_US),
    .OFF_US    (OFF_US),
    .POLL_MAX  (POLL_MAX)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .tick_clr    (tick_clr),
    .cmd_en      (cmd_enable),
    .cmd_dis     (cmd_disable),
    .vote_mode   (vote_en_q),
    .lock_det    (lock_det),
    .active_flag (active_flag),
    .ctl_we      (wr_en),
    .ctl_wdata   (wr_data[2:0]),
    .oe          (pll_out_en),
    .byp_n       (pll_bypass_n),
    .rst_n       (pll_reset_n),
    .vote_req    (vote_req),
    .busy        (busy),
    .done        (done),
    .timeout     (timeout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_cnt_q <= '0;
      bias_cnt_q <= '0;
      vote_en_q  <= 1'b0;
    end else if (wr_en && !busy) begin
      lock_cnt_q <= wr_data[LCNT_LSB +: FIELD_W];
      bias_cnt_q <= wr_data[BCNT_LSB +: FIELD_W];
      vote_en_q  <= wr_data[VOTE_BIT];
    end
  end

  always_comb begin
    mode_rdata                      = '0;
    mode_rdata[OE_BIT]              = pll_out_en;
    mode_rdata[BYPN_BIT]            = pll_bypass_n;
    mode_rdata[RSTN_BIT]            = pll_reset_n;
    mode_rdata[LCNT_LSB +: FIELD_W] = lock_cnt_q;
    mode_rdata[BCNT_LSB +: FIELD_W] = bias_cnt_q;
    mode_rdata[VOTE_BIT]            = vote_en_q;
    mode_rdata[ACT_BIT]             = active_flag;
    mode_rdata[LOCK_BIT]            = lock_det;
  end
endmodule

// File: rtl/pllseq_chk.sv
module pllseq_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        lock_det,
  input logic        pll_out_en,
  input logic        pll_bypass_n,
  input logic        pll_reset_n,
  input logic        busy,
  input logic        done,
  input logic        timeout,
  input logic [31:0] mode_rdata
);
  // R4: output gate rises by sequence only after lock was seen
  a_r4_gate_after_lock: assert property (@(posedge clk) disable iff (rst)
    ($rose(pll_out_en) && !$past(wr_en)) |-> $past(lock_det));

  // R4: reset-not is released only while bypass-not is already high
  a_r4_reset_after_bypass: assert property (@(posedge clk) disable iff (rst)
    ($rose(pll_reset_n) && !$past(wr_en)) |-> (pll_bypass_n && $past(pll_bypass_n)));

  // R6: reset-not and bypass-not fall together
  a_r6_drop_together: assert property (@(posedge clk) disable iff (rst)
    ($fell(pll_reset_n) && !$past(wr_en)) |-> $fell(pll_bypass_n));

  // R6: output already gated when reset-not falls
  a_r6_gate_first: assert property (@(posedge clk) disable iff (rst)
    ($fell(pll_reset_n) && !$past(wr_en)) |-> (!pll_out_en && !$past(pll_out_en)));

  // R5: a direct-mode timeout never leaves the output gate open
  a_r5_no_gate_on_timeout: assert property (@(posedge clk) disable iff (rst)
    (timeout && !mode_rdata[20]) |-> !pll_out_en);

  // R9: writable fields hold while a sequence runs
  a_r9_fields_hold: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(mode_rdata[20:8]));

  // R10: done and timeout are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout));
endmodule

bind pllseq pllseq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .lock_det     (lock_det),
  .pll_out_en   (pll_out_en),
  .pll_bypass_n (pll_bypass_n),
  .pll_reset_n  (pll_reset_n),
  .busy         (busy),
  .done         (done),
  .timeout      (timeout),
  .mode_rdata   (mode_rdata)
);

// File: tb/pllseq_bench.sv
module pllseq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  tick_div = 8'd3;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] mode_rdata;
  logic        cmd_enable = 1'b0;
  logic        cmd_disable = 1'b0;
  logic        lock_det = 1'b0;
  logic        active_flag = 1'b0;
  logic        pll_out_en, pll_bypass_n, pll_reset_n, vote_req, busy, done, timeout;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // {wdata[31:0], lock, active, expected readback[31:0]}
  localparam logic [65:0] VEC [7] = '{
    {32'hFFFF_FFFF, 1'b0, 1'b0, 32'h001F_FF07},
    {32'h0000_0000, 1'b1, 1'b0, 32'h8000_0000},
    {32'h0000_2A00, 1'b0, 1'b1, 32'h4000_2A00},
    {32'h000D_4000, 1'b1, 1'b1, 32'hC00D_4000},
    {32'hFFE0_00F8, 1'b0, 1'b0, 32'h0000_0000},
    {32'h0000_0006, 1'b0, 1'b0, 32'h0000_0006},
    {32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000}
  };

  pllseq u_pllseq (
    .clk(clk), .rst(rst), .tick_div(tick_div), .wr_en(wr_en), .wr_data(wr_data),
    .mode_rdata(mode_rdata), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .lock_det(lock_det), .active_flag(active_flag), .pll_out_en(pll_out_en),
    .pll_bypass_n(pll_bypass_n), .pll_reset_n(pll_reset_n), .vote_req(vote_req),
    .busy(busy), .done(done), .timeout(timeout)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_en();
    @(negedge clk); cmd_enable = 1'b1;
    @(negedge clk); cmd_enable = 1'b0;
  endtask

  task automatic pulse_dis();
    @(negedge clk); cmd_disable = 1'b1;
    @(negedge clk); cmd_disable = 1'b0;
  endtask

  task automatic pins(input string req, input logic oe, input logic bn, input logic rn);
    check(req, {29'd0, pll_out_en, pll_bypass_n, pll_reset_n}, {29'd0, oe, bn, rn});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    check("R1 readback", mode_rdata, 32'h0);
    pins("R1 pins", 0, 0, 0);
    check("R1 status", {vote_req, busy, done, timeout}, 4'b0000);

    // R2 register layout table
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_data = VEC[i][65:34];
      lock_det = VEC[i][33]; active_flag = VEC[i][32];
      @(negedge clk);
      wr_en = 1'b0;
      check("R2 readback", mode_rdata, VEC[i][31:0]);
    end
    lock_det = 1'b0; active_flag = 1'b0;

    // R4 direct start, tick = 4 clocks, bypass delay 5 ticks
    pulse_en();
    pins("R4 bypass first", 0, 1, 0);
    check("R9 busy during start", {31'd0, busy}, 1);
    cyc(19);
    pins("R4 reset held before delay", 0, 1, 0);
    cyc(1);
    pins("R4 reset released at delay", 0, 1, 1);
    cyc(5);
    pins("R4 gate waits for lock", 0, 1, 1);
    lock_det = 1'b1;
    cyc(1);
    pins("R4 gate after lock", 1, 1, 1);
    check("R4 done", {30'd0, done, busy}, 2'b10);
    cyc(1);
    check("R10 done is a pulse", {31'd0, done}, 0);

    // R3 skip when already running
    pulse_en();
    check("R3 skip done", {30'd0, done, busy}, 2'b10);
    pins("R3 pins unchanged", 1, 1, 1);

    // R6 direct stop, with an ignored start request in the middle (R9)
    pulse_dis();
    pins("R6 gate cleared first", 0, 1, 1);
    pulse_en();
    cyc(1);
    pins("R6 reset held one tick", 0, 1, 1);
    cyc(1);
    pins("R6 reset and bypass dropped", 0, 0, 0);
    check("R6 done", {30'd0, done, busy}, 2'b10);
    cyc(2);
    pins("R9 start while busy ignored", 0, 0, 0);
    check("R9 idle after ignored start", {31'd0, busy}, 0);
    lock_det = 1'b0;

    // R5 lock timeout: 5 + 100 ticks from the request
    pulse_en();
    cyc(419);
    check("R5 still waiting", {30'd0, busy, timeout}, 2'b10);
    cyc(1);
    check("R5 timeout", {29'd0, busy, timeout, done}, 3'b010);
    pins("R5 gate stays closed", 0, 1, 1);
    cyc(1);
    check("R10 timeout is a pulse", {31'd0, timeout}, 0);

    // R7 vote start
    write_reg(32'h0010_0006);
    check("R2 vote mode readback", mode_rdata, 32'h0010_0006);
    pulse_en();
    check("R7 vote raised", {30'd0, vote_req, busy}, 2'b11);
    pins("R7 pins untouched", 0, 1, 1);
    write_reg(32'h0000_0000);
    check("R9 write while busy ignored", mode_rdata, 32'h0010_0006);
    active_flag = 1'b1;
    cyc(1);
    check("R7 done on active", {29'd0, done, busy, vote_req}, 3'b101);
    active_flag = 1'b0;

    // R8 vote stop
    pulse_dis();
    check("R8 vote withdrawn", {29'd0, vote_req, done, busy}, 3'b010);
    pins("R8 pins untouched", 0, 1, 1);

    // R7 vote timeout after 100 ticks
    pulse_en();
    cyc(399);
    check("R7 vote still waiting", {30'd0, busy, timeout}, 2'b10);
    cyc(1);
    check("R7 vote timeout", {29'd0, timeout, done, vote_req}, 3'b101);

    // R1 reset in the middle of a direct start
    write_reg(32'h0000_0000);
    pulse_en();
    cyc(2);
    rst = 1'b1;
    cyc(2);
    check("R1 mid-sequence reset readback", mode_rdata, 32'h0);
    check("R1 mid-sequence reset status", {27'd0, pll_out_en, pll_bypass_n, pll_reset_n, vote_req, busy}, 0);
    rst = 1'b0;
    cyc(2);
    finish_run();
  end
endmodule